// File: doc/BRIEF.md
# APM Command Port with SMI Trigger

This block is an 8-bit command register through which the operating system hands a byte to a system-management interrupt (SMI) handler. It answers at one fixed I/O address and only to byte-sized accesses. A qualifying write stores the byte. If both SMI enables are set, the write also fires a one-cycle SMI request toward the interrupt logic. A qualifying read returns the byte last stored. If the stop-clock enable is set, the read also raises a stop-clock request, which stays up until the clock-control logic acknowledges it.

The enables come from control registers elsewhere in the chip. The block only samples them in the cycle of the access strobe. The byte held in the register is opaque payload. Its value never changes what the block does.

Top module: `apm_cmd_port`

## Requirements
- R1: After reset the stored byte is 00h, and `smiReq`, `stopClkReq` and `rdValid` are all 0.
- R2: A qualifying write stores `wrData`. A later qualifying read produces `rdValid`=1 with `rdData` equal to the last byte stored, in the cycle after the read strobe. An access qualifies when `ioAddr`=00B2h and `ioSize`=2'b00 (byte).
- R3: A qualifying write raises `smiReq` in the cycle after the strobe only when `smiGlobalEn`=1 and `smiPortEn`=1 during the strobe cycle. With either enable at 0 there is no SMI request.
- R4: `smiReq` is a single-cycle pulse. It is high only in the cycle that directly follows a qualifying write strobe.
- R5: A qualifying read sets `stopClkReq` in the cycle after the strobe when `stopClkEn`=1. With `stopClkEn`=0 the read leaves `stopClkReq` unchanged.
- R6: Once set, `stopClkReq` stays at 1 until a cycle with `stopClkAck`=1, after which it is 0. A new set in the same cycle as an acknowledge wins.
- R7: A read never raises `smiReq`, whatever the enables are.
- R8: An access with `ioSize` other than 2'b00, or with any address other than 00B2h, changes no stored data and raises no `smiReq`, `stopClkReq` or `rdValid`.
- R9: The stored byte has no effect on behaviour. Writes of 00h and FFh under the same enables give the same request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address of the access |
| ioSize | input | 2 | Access size, 2'b00 = byte |
| ioWrStb | input | 1 | One-cycle write strobe |
| ioRdStb | input | 1 | One-cycle read strobe |
| wrData | input | 8 | Write byte |
| smiGlobalEn | input | 1 | Global SMI enable |
| smiPortEn | input | 1 | Enable for SMI on port writes |
| stopClkEn | input | 1 | Enable for stop-clock on port reads |
| stopClkAck | input | 1 | Clears the stop-clock request |
| rdData | output | 8 | Read byte, valid with rdValid |
| rdValid | output | 1 | Read data valid pulse |
| smiReq | output | 1 | SMI request pulse |
| stopClkReq | output | 1 | Held stop-clock request |

## Verification
The properties assume that the access strobes are single-cycle and that the enables are steady during the strobe cycle. They also assume that a read and a write are not issued in the same cycle. The driver tasks raise exactly one strobe for one cycle, set the enables and address before that cycle, and drop everything in the next cycle. The acknowledge is pulsed only from its own task, so it never lines up with a read strobe.

// File: rtl/apm_pkg.sv
package apm_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadByte;     // store the write byte
    logic captureRead;  // present stored byte on read port
  } apmStrobes_t;
endpackage

// File: rtl/apm_ctl.sv
module apm_ctl
  import apm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 2,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h00B2,
  parameter logic [SIZE_W-1:0] SIZE_BYTE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [SIZE_W-1:0] ioSize,
  input  logic              ioWrStb,
  input  logic              ioRdStb,
  input  logic              smiGlobalEn,
  input  logic              smiPortEn,
  input  logic              stopClkEn,
  input  logic              stopClkAck,
  output apmStrobes_t       strobes,
  output logic              rdValid,
  output logic              smiReq,
  output logic              stopClkReq
);
  logic addrHit;
  logic sizeOk;
  logic portHit;
  logic wrHit;
  logic rdHit;
  logic smiFire;
  logic stopSet;

  // Decode: exact address and byte-size access only
  assign addrHit = (ioAddr == PORT_ADDR);
  assign sizeOk  = (ioSize == SIZE_BYTE);
  assign portHit = addrHit && sizeOk;
  assign wrHit   = ioWrStb && portHit;
  assign rdHit   = ioRdStb && portHit;

  // Side-effect qualification
  assign smiFire = wrHit && smiGlobalEn && smiPortEn;
  assign stopSet = rdHit && stopClkEn;

  always_comb begin
    strobes             = '0;
    strobes.loadByte    = wrHit;
    strobes.captureRead = rdHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      smiReq     <= 1'b0;
      rdValid    <= 1'b0;
      stopClkReq <= 1'b0;
    end else begin
      smiReq  <= smiFire;
      rdValid <= rdHit;
      if (stopSet)
        stopClkReq <= 1'b1;
      else if (stopClkAck)
        stopClkReq <= 1'b0;
    end
  end
endmodule

// File: rtl/apm_dp.sv
module apm_dp
  import apm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  apmStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] storedByte,
  output logic [DATA_W-1:0] rdData
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedByte <= '0;
      rdData     <= '0;
    end else begin
      if (strobes.loadByte)
        storedByte <= wrData;
      if (strobes.captureRead)
        rdData <= storedByte;
    end
  end
endmodule

// File: rtl/apm_cmd_port.sv
module apm_cmd_port
  import apm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SIZE_W = 2,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h00B2,
  parameter logic [SIZE_W-1:0] SIZE_BYTE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [SIZE_W-1:0] ioSize,
  input  logic              ioWrStb,
  input  logic              ioRdStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              smiGlobalEn,
  input  logic              smiPortEn,
  input  logic              stopClkEn,
  input  logic              stopClkAck,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              smiReq,
  output logic              stopClkReq
);
  apmStrobes_t       strobes;
  logic [DATA_W-1:0] storedByte;

  apm_ctl #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
    .PORT_ADDR(PORT_ADDR), .SIZE_BYTE(SIZE_BYTE)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioSize(ioSize),
    .ioWrStb(ioWrStb), .ioRdStb(ioRdStb),
    .smiGlobalEn(smiGlobalEn), .smiPortEn(smiPortEn),
    .stopClkEn(stopClkEn), .stopClkAck(stopClkAck),
    .strobes(strobes), .rdValid(rdValid), .smiReq(smiReq),
    .stopClkReq(stopClkReq)
  );

  apm_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .storedByte(storedByte), .rdData(rdData)
  );
endmodule

// File: rtl/apm_cmd_chk.sv
module apm_cmd_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SIZE_W = 2,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h00B2,
  parameter logic [SIZE_W-1:0] SIZE_BYTE = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [SIZE_W-1:0] ioSize,
  input logic              ioWrStb,
  input logic              ioRdStb,
  input logic              smiGlobalEn,
  input logic              smiPortEn,
  input logic              stopClkEn,
  input logic              stopClkAck,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              smiReq,
  input logic              stopClkReq,
  input logic [DATA_W-1:0] storedByte
);
  logic hit;
  assign hit = (ioAddr == PORT_ADDR) && (ioSize == SIZE_BYTE);

  a_r3_smi_when_enabled: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrStb && hit && smiGlobalEn && smiPortEn) |=> smiReq);

  a_r4_smi_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    smiReq |-> $past(ioWrStb && hit && smiGlobalEn && smiPortEn));

  a_r7_read_no_smi: assert property (@(posedge clk) disable iff (!rstN)
    (ioRdStb && !ioWrStb) |=> !smiReq);

  a_r2_read_returns_byte: assert property (@(posedge clk) disable iff (!rstN)
    (ioRdStb && hit) |=> (rdValid && rdData == $past(storedByte)));

  a_r6_stop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stopClkReq && !stopClkAck) |=> stopClkReq);

  a_r5_stop_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopClkReq) |-> $past(ioRdStb && hit && stopClkEn));

  a_r8_ignored_keeps_byte: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrStb && !hit) |=> $stable(storedByte));
endmodule

bind apm_cmd_port apm_cmd_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
  .PORT_ADDR(PORT_ADDR), .SIZE_BYTE(SIZE_BYTE)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioSize(ioSize),
  .ioWrStb(ioWrStb), .ioRdStb(ioRdStb),
  .smiGlobalEn(smiGlobalEn), .smiPortEn(smiPortEn),
  .stopClkEn(stopClkEn), .stopClkAck(stopClkAck),
  .rdData(rdData), .rdValid(rdValid), .smiReq(smiReq),
  .stopClkReq(stopClkReq), .storedByte(storedByte)
);

// File: tb/sim_apm_cmd_port.sv
module sim_apm_cmd_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [1:0]  ioSize = '0;
  logic ioWrStb = 1'b0, ioRdStb = 1'b0;
  logic [7:0] wrData = '0;
  logic smiGlobalEn = 1'b0, smiPortEn = 1'b0, stopClkEn = 1'b0, stopClkAck = 1'b0;
  logic [7:0] rdData;
  logic rdValid, smiReq, stopClkReq;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] model = 8'h00;
  logic [7:0] expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  apm_cmd_port u0 (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioSize(ioSize),
    .ioWrStb(ioWrStb), .ioRdStb(ioRdStb), .wrData(wrData),
    .smiGlobalEn(smiGlobalEn), .smiPortEn(smiPortEn),
    .stopClkEn(stopClkEn), .stopClkAck(stopClkAck),
    .rdData(rdData), .rdValid(rdValid), .smiReq(smiReq),
    .stopClkReq(stopClkReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read bytes
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R8 actual=unexpected rdValid expected=none");
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check("R2 read data", rdData, e);
      end
    end
  end

  // Driver: one access; returns smiReq seen in the following cycle
  task automatic access(input bit isWr, input logic [15:0] a, input logic [1:0] sz,
                        input logic [7:0] d, output logic smiSeen);
    @(negedge clk);
    ioAddr = a; ioSize = sz; wrData = d;
    ioWrStb = isWr; ioRdStb = !isWr;
    if (a == 16'h00B2 && sz == 2'b00) begin
      if (isWr) model = d;
      else expQ.push_back(model);
    end
    @(negedge clk);
    ioWrStb = 0; ioRdStb = 0;
    smiSeen = smiReq;
  endtask

  task automatic ack();
    @(negedge clk);
    stopClkAck = 1;
    @(negedge clk);
    stopClkAck = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic s;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 rdData", rdData, 8'h00);
    check("R1 smiReq", {7'b0, smiReq}, 8'h0);
    check("R1 stopClkReq", {7'b0, stopClkReq}, 8'h0);
    check("R1 rdValid", {7'b0, rdValid}, 8'h0);
    access(0, 16'h00B2, 2'b00, 8'h00, s);   // R1 reset byte read back

    // R3 enable combinations
    access(1, 16'h00B2, 2'b00, 8'hA5, s);
    check("R3 no enables", {7'b0, s}, 8'h0);
    smiGlobalEn = 1;
    access(1, 16'h00B2, 2'b00, 8'h3C, s);
    check("R3 global only", {7'b0, s}, 8'h0);
    smiGlobalEn = 0; smiPortEn = 1;
    access(1, 16'h00B2, 2'b00, 8'h5A, s);
    check("R3 port only", {7'b0, s}, 8'h0);
    smiGlobalEn = 1;
    access(1, 16'h00B2, 2'b00, 8'h00, s);
    check("R3 both enables", {7'b0, s}, 8'h1);
    @(negedge clk);
    check("R4 pulse width", {7'b0, smiReq}, 8'h0);
    // R9: FFh gives same outcome as 00h
    access(1, 16'h00B2, 2'b00, 8'hFF, s);
    check("R9 value independent", {7'b0, s}, 8'h1);
    access(0, 16'h00B2, 2'b00, 8'h00, s);   // R2 returns FF
    check("R7 read no smi", {7'b0, s}, 8'h0);
    check("R5 no stop when disabled", {7'b0, stopClkReq}, 8'h0);

    // R5/R6 stop-clock
    stopClkEn = 1;
    access(0, 16'h00B2, 2'b00, 8'h00, s);
    check("R5 stop set", {7'b0, stopClkReq}, 8'h1);
    repeat (4) @(negedge clk);
    check("R6 stop held", {7'b0, stopClkReq}, 8'h1);
    ack();
    check("R6 stop cleared", {7'b0, stopClkReq}, 8'h0);

    // R8 ignored accesses
    access(1, 16'h00B2, 2'b01, 8'h11, s);
    check("R8 wrong size write smi", {7'b0, s}, 8'h0);
    access(1, 16'h00B3, 2'b00, 8'h22, s);
    check("R8 wrong addr write smi", {7'b0, s}, 8'h0);
    access(0, 16'h00B2, 2'b10, 8'h00, s);
    check("R8 wrong size read stop", {7'b0, stopClkReq}, 8'h0);
    access(0, 16'h0070, 2'b00, 8'h00, s);
    check("R8 wrong addr read stop", {7'b0, stopClkReq}, 8'h0);
    access(0, 16'h00B2, 2'b00, 8'h00, s);   // R8: still FF
    ack();
    repeat (3) @(negedge clk);
    check("R2 queue drained", 8'(expQ.size()), 8'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule